// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Alignment

This block turns the two phase signals of an incremental encoder, plus its once-per-turn index pulse, into a signed 32-bit position count. All three inputs come from the pins unsynchronized. They pass through two-flop synchronizers into the system clock domain before any decoding takes place. The decoder counts every legal Gray-code transition of the phase pair, giving four counts per encoder line. An illegal transition, where both phases change at once, is flagged and not counted.

An index unit watches the rising edge of the synchronized index signal. It can zero the count on every index edge, only on the first one, or never. A sticky marker reports that an index edge has been seen. The index edge and a phase edge can be skewed by a few clocks in either direction. To handle this, a recognized index edge opens a short pairing window. If a quadrature step falls inside that window, the count is zeroed on that step. If no step comes, the count is zeroed when the window closes. An index edge that leads or trails its phase edge is therefore never lost.

Top module: `qd_position_decoder`

## Requirements
- R1: After reset, `position` is 0 and `first_idx_flag` and `phase_err` are 0.
- R2: A change on a raw phase input first shows in `position` after the third rising clock edge that samples it, and not after the second.
- R3: Phase pair {A,B} stepping along 00→10→11→01→00 adds one per transition, and the reverse order subtracts one per transition.
- R4: A transition that changes A and B together leaves `position` unchanged and sets `phase_err`. The flag stays set until `flag_clr` is pulsed.
- R5: With `idx_mode` = 2'b00, every index event sets `position` to 0.
- R6: With `idx_mode` = 2'b10, only the first index event after reset or after a `flag_clr` zeroes `position`. Later events leave the count alone until the marker is cleared again.
- R7: With `idx_mode` = 2'b01 or 2'b11, index events never change `position`, but `first_idx_flag` is still set.
- R8: `first_idx_flag` is set by an index event and stays set until a `flag_clr` pulse. An event in the same cycle as the clear keeps the flag set.
- R9: An index rising edge that lands one clock before, in the same clock as, or two clocks after a phase edge is still recognized. The count is zeroed in the resetting modes and the marker is set.
- R10: When the index zeroes the count in the same cycle as a quadrature step, the count becomes 0 and the step is dropped.
- R11: An index rising edge with no phase edge nearby zeroes `position` after the fifth rising clock edge from the raw index change, and not earlier.
- R12: The count wraps modulo 2^32 (0 minus one step gives 32'hFFFF_FFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_in | input | 1 | Raw encoder phase A |
| phase_b_in | input | 1 | Raw encoder phase B |
| index_in | input | 1 | Raw encoder index pulse |
| idx_mode | input | 2 | 00 zero on every index, 10 zero on first index only, 01/11 never zero |
| flag_clr | input | 1 | One-cycle strobe that clears `first_idx_flag` and `phase_err` |
| position | output | 32 | Signed position count |
| first_idx_flag | output | 1 | Sticky marker: an index event has been seen |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
A phase change driven between clock edges reaches `position` on the third rising edge: two synchronizer stages, then the count register. A lone index edge zeroes the count on the fifth edge, because the three-cycle pairing window adds two more edges. The bench samples on falling edges. The latency checks look exactly at the edges before and at the point where the value is due. All other checks wait eight quiet cycles after each stimulus, so every pipeline and window has drained before the bench compares against its own model. For the skew cases, the index and the phase edge are placed at fixed falling-edge offsets from −1 to +2 cycles, and the settled result is checked.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    IDX_EVERY  = 2'b00,
    IDX_OFF_A  = 2'b01,
    IDX_FIRST  = 2'b10,
    IDX_OFF_B  = 2'b11
  } idx_mode_e;
endpackage

// File: rtl/qd_sync.sv
// Multi-stage synchronizer per bit, plus a one-cycle delayed copy for edge detection.
module qd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] dly_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], raw_i[i]};
    end
    assign sync_o[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) dly_o <= '0;
    else     dly_o <= sync_o;
  end
endmodule

// File: rtl/qd_step_decode.sv
// Gray-code step decode of the phase pair; bit 1 is A, bit 0 is B.
module qd_step_decode (
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  output logic       step_o,
  output logic       up_o,
  output logic       bad_o
);
  logic [1:0] chg;
  always_comb begin
    chg    = cur_i ^ prev_i;
    step_o = ^chg;
    bad_o  = &chg;
    up_o   = (prev_i[1] == cur_i[0]);
  end
endmodule

// File: rtl/qd_index_unit.sv
// Index event pairing window, reset-mode policy and sticky first-index marker.
module qd_index_unit #(
  parameter int WIN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_rise_i,
  input  logic       step_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       apply_o,
  output logic       zero_o,
  output logic       flag_o
);
  import qd_pkg::*;
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] win_cnt;
  logic          open_win;
  logic          last_cyc;
  idx_mode_e     mode;

  always_comb begin
    mode     = idx_mode_e'(mode_i);
    open_win = idx_rise_i || (win_cnt != '0);
    last_cyc = idx_rise_i ? (WIN == 1) : (win_cnt == CW'(WIN - 1));
    apply_o  = open_win && (step_i || last_cyc);
    unique case (mode)
      IDX_EVERY: zero_o = apply_o;
      IDX_FIRST: zero_o = apply_o && !flag_o;
      default:   zero_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  win_cnt <= '0;
    else if (apply_o)         win_cnt <= '0;
    else if (idx_rise_i)      win_cnt <= CW'(1);
    else if (win_cnt != '0)   win_cnt <= win_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_o <= 1'b0;
    else if (apply_o) flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/qd_position_decoder.sv
module qd_position_decoder #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_WIN     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a_in,
  input  logic             phase_b_in,
  input  logic             index_in,
  input  logic [1:0]       idx_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] position,
  output logic             first_idx_flag,
  output logic             phase_err
);
  localparam int NIN = 3;

  logic [NIN-1:0] s_cur, s_prev;
  logic step_en, step_up, step_bad;
  logic idx_rise, idx_apply, idx_zero;

  qd_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .raw_i({phase_a_in, phase_b_in, index_in}),
    .sync_o(s_cur), .dly_o(s_prev)
  );

  qd_step_decode u_dec (
    .cur_i(s_cur[2:1]), .prev_i(s_prev[2:1]),
    .step_o(step_en), .up_o(step_up), .bad_o(step_bad)
  );

  assign idx_rise = s_cur[0] && !s_prev[0];

  qd_index_unit #(.WIN(IDX_WIN)) u_idx (
    .clk(clk), .rst(rst), .idx_rise_i(idx_rise), .step_i(step_en),
    .mode_i(idx_mode), .clr_i(flag_clr),
    .apply_o(idx_apply), .zero_o(idx_zero), .flag_o(first_idx_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)           position <= '0;
    else if (idx_zero) position <= '0;
    else if (step_en)  position <= position + (step_up ? CNT_W'(1) : {CNT_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst)           phase_err <= 1'b0;
    else if (step_bad) phase_err <= 1'b1;
    else if (flag_clr) phase_err <= 1'b0;
  end
endmodule

// File: rtl/qd_checker.sv
module qd_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             flag_clr,
  input logic [1:0]       idx_mode,
  input logic [CNT_W-1:0] position,
  input logic             first_idx_flag,
  input logic             phase_err,
  input logic             step_en,
  input logic             idx_apply,
  input logic             idx_zero
);
  assert_step_size_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(idx_zero) |-> (position == $past(position)) ||
      (position == $past(position) + CNT_W'(1)) || (position == $past(position) - CNT_W'(1)));

  assert_step_moves_R3: assert property (@(posedge clk) disable iff (rst)
    step_en && !idx_zero |=> position != $past(position));

  assert_zero_wins_R10: assert property (@(posedge clk) disable iff (rst)
    idx_zero |=> position == '0);

  assert_no_reset_off_R7: assert property (@(posedge clk) disable iff (rst)
    idx_mode[0] |-> !idx_zero);

  assert_one_shot_R6: assert property (@(posedge clk) disable iff (rst)
    idx_zero && idx_mode == 2'b10 |-> !first_idx_flag);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
    first_idx_flag && !$past(first_idx_flag) |-> $past(idx_apply));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(first_idx_flag) && !$past(flag_clr) |-> first_idx_flag);

  assert_perr_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    $past(phase_err) && !$past(flag_clr) |-> phase_err);
endmodule

bind qd_position_decoder qd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .flag_clr(flag_clr), .idx_mode(idx_mode),
  .position(position), .first_idx_flag(first_idx_flag), .phase_err(phase_err),
  .step_en(step_en), .idx_apply(idx_apply), .idx_zero(idx_zero)
);

// File: tb/test_qd_position_decoder.sv
`timescale 1ns/1ps
module test_qd_position_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pa = 1'b0, pb = 1'b0, pi = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        clr = 1'b0;
  logic [31:0] position;
  logic        fflag, perr;

  int tests = 0, fails = 0;
  logic [31:0] exp_pos = '0;
  logic        exp_flag = 1'b0, exp_perr = 1'b0;
  int          q = 0;

  always #5 clk = ~clk;

  qd_position_decoder i_qd_position_decoder (
    .clk(clk), .rst(rst), .phase_a_in(pa), .phase_b_in(pb), .index_in(pi),
    .idx_mode(mode), .flag_clr(clr), .position(position),
    .first_idx_flag(fflag), .phase_err(perr)
  );

  function automatic logic [1:0] gray(int s);
    case (s & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic resets_now(logic [1:0] m, logic f);
    return (m == 2'b00) || (m == 2'b10 && !f);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic check_all(string req);
    check({req, " position"}, position, exp_pos);
    check({req, " first flag"}, {31'd0, fflag}, {31'd0, exp_flag});
    check({req, " phase err"}, {31'd0, perr}, {31'd0, exp_perr});
  endtask

  task automatic drive_q();
    {pa, pb} = gray(q);
  endtask

  task automatic step(int dir);
    q = (q + dir) & 3;
    drive_q();
    exp_pos = exp_pos + 32'(dir);
    settle();
  endtask

  task automatic illegal();
    q = (q + 2) & 3;
    drive_q();
    exp_perr = 1'b1;
    settle();
  endtask

  task automatic clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_flag = 1'b0;
    exp_perr = 1'b0;
    settle();
  endtask

  // off: index edge position relative to the phase edge, in clocks (-1..2)
  task automatic idx_pair(int off, int dir);
    logic rz;
    rz = resets_now(mode, exp_flag);
    for (int k = -1; k <= 3; k++) begin
      if (k == 0) begin q = (q + dir) & 3; drive_q(); end
      if (k == off) pi = 1'b1;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    pi = 1'b0;
    exp_pos  = rz ? 32'd0 : exp_pos + 32'(dir);
    exp_flag = 1'b1;
    settle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    // R2 latency: visible after third edge, not second
    q = 1; drive_q();
    repeat (2) @(negedge clk);
    check("R2 not before 3rd edge", position, 32'd0);
    @(negedge clk);
    check("R2 at 3rd edge", position, 32'd1);
    exp_pos = 32'd1;
    settle();

    // R3 forward and reverse
    for (int i = 0; i < 6; i++) step(1);
    check_all("R3 forward");
    for (int i = 0; i < 9; i++) step(-1);
    check_all("R3 reverse");

    // R12 wrap
    while (exp_pos != 0) step(exp_pos[31] ? 1 : -1);
    step(-1);
    check("R12 wrap below zero", position, 32'hFFFF_FFFF);

    // R4 illegal transition
    illegal();
    check_all("R4 double change");
    step(1);
    check_all("R4 sticky");
    clear();
    check_all("R4 cleared");

    // R11 lone index latency, mode 00
    mode = 2'b00;
    step(1); step(1);
    pi = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 not before 5th edge", position, exp_pos);
    @(negedge clk);
    check("R11 at 5th edge", position, 32'd0);
    pi = 1'b0;
    exp_pos = 0; exp_flag = 1'b1;
    settle();
    check_all("R5 R8 lone index");

    // R9/R10 skew cases in mode 00
    for (int off = -1; off <= 2; off++) begin
      step(1); step(1); step(1);
      idx_pair(off, 1);
      check_all($sformatf("R9 R10 R5 skew %0d", off));
    end

    // R8 event with simultaneous clear keeps flag
    clear();
    step(1);
    pi = 1'b1;
    repeat (4) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    pi = 1'b0;
    exp_pos = 0; exp_flag = 1'b1; exp_perr = 1'b0;
    settle();
    check_all("R8 set beats clear");

    // R6 first-only mode with re-arm
    mode = 2'b10;
    clear();
    step(1); step(1);
    idx_pair(-1, 1);
    check_all("R6 first zeroes");
    step(1); step(1);
    idx_pair(2, 1);
    check_all("R6 later ignored");
    clear();
    idx_pair(0, -1);
    check_all("R6 re-armed");

    // R7 modes with reset disabled
    mode = 2'b01;
    clear();
    step(1); step(1);
    idx_pair(1, 1);
    check_all("R7 mode 01");
    mode = 2'b11;
    clear();
    idx_pair(-1, -1);
    check_all("R7 mode 11");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(99);
      if (r < 65)      step($urandom_range(1) ? 1 : -1);
      else if (r < 80) idx_pair(int'($urandom_range(3)) - 1, $urandom_range(1) ? 1 : -1);
      else if (r < 86) clear();
      else if (r < 93) begin mode = 2'($urandom_range(3)); settle(); end
      else             illegal();
      check_all("R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule